// File: doc/BRIEF.md
# Round-Robin Trim Cell Sequencer

This block walks a background trimming loop around a ring of 32 unary current cells, one cell at a time. Thirty-one cells are the large segment cells. The thirty-second cell is the one whose current is split to feed the finer array. Exactly one cell is wired to the loop while the block is enabled. Each accepted trim tick starts a handover to the next cell in a fixed order. After the last cell the order wraps to the first.

A handover glides rather than jumps. First a sample strobe captures the bias node of the next cell onto a holding capacitor, while the current cell is still being trimmed. After one quiet cycle, a transfer strobe copies that held voltage onto the loop node. After one more quiet cycle, the select moves to the next cell. The loop node therefore already sits at the right level when the new cell connects, so the switch-over makes no glitch. Clearing the enable releases every cell and abandons any handover in progress.

Top module: `calib_sequencer`

## Requirements
- R1: After reset the active index is 0, no handover is in progress, and both strobes are low.
- R2: Each accepted trim tick moves the active index up by exactly one. From index CELLS-1 (31) it wraps to 0.
- R3: While enable is high, exactly one select bit is high, and it is bit number activeIdx. When selected, cell n drives bit n of the select vector.
- R4: A tick sampled high at a clock edge while idle and enabled raises sampleStb from that edge onward for SAMPLE_LEN cycles (default 4).
- R5: After the sample window, both strobes stay low for one cycle. xferStb is then high for XFER_LEN cycles (default 3).
- R6: sampleStb and xferStb are never high together. xferStb never rises in the cycle right after sampleStb was high.
- R7: xferStb is low for the cycle before the index changes. The index changes at the edge SAMPLE_LEN+XFER_LEN+2 cycles after the tick edge. Every index change is preceded by a transfer window.
- R8: A trim tick that arrives while a handover is in progress is ignored. It causes no second advance and does not restart the strobes.
- R9: While enable is low, all select bits and both strobes are low and the index is held. A handover cut off by enable going low does not resume when enable returns.
- R10: A trim tick that arrives while enable is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Enables the sequencer; when low it releases all cells |
| trimTick | input | 1 | One-cycle request to hand the loop to the next cell |
| cellSel | output | 32 | One-hot connect select; bit n connects cell n |
| sampleStb | output | 1 | Captures the next cell's bias onto the holding capacitor |
| xferStb | output | 1 | Copies the held voltage onto the loop node |
| activeIdx | output | 5 | Index of the cell wired to the loop |

## Verification
The assertions take for granted that trimTick and enable are synchronous to clk and settle away from the clock edge. They also assume reset is held for at least one edge, so the index starts from a known value. The stimulus drives both inputs only on the falling edge. It pulses trimTick for one cycle at a time, and it does so both while idle and in the middle of a handover. It drops enable only between edges: once inside a sample window, and once while idle with a tick arriving.

// File: rtl/calseq_pkg.sv
package calseq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SAMPLE = 3'd1,
    PH_GAP_A  = 3'd2,
    PH_XFER   = 3'd3,
    PH_GAP_B  = 3'd4
  } seqPhase_t;

  typedef struct packed {
    logic sampleOn;
    logic xferOn;
    logic advance;
  } seqStrobes_t;

endpackage

// File: rtl/calseq_ctrl.sv
module calseq_ctrl
  import calseq_pkg::*;
#(
  parameter int SAMPLE_LEN = 4,
  parameter int XFER_LEN   = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        trimTick,
  output seqStrobes_t stb
);

  localparam int MAX_LEN = (SAMPLE_LEN > XFER_LEN) ? SAMPLE_LEN : XFER_LEN;
  localparam int CW      = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
  localparam logic [CW-1:0] SAMPLE_LAST = CW'(SAMPLE_LEN - 1);
  localparam logic [CW-1:0] XFER_LAST   = CW'(XFER_LEN - 1);

  seqPhase_t       phase;
  logic [CW-1:0]   phaseCnt;

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      phase    <= PH_IDLE;
      phaseCnt <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          phaseCnt <= '0;
          if (trimTick) phase <= PH_SAMPLE;
        end
        PH_SAMPLE: begin
          if (phaseCnt == SAMPLE_LAST) begin
            phase    <= PH_GAP_A;
            phaseCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        PH_GAP_A: phase <= PH_XFER;
        PH_XFER: begin
          if (phaseCnt == XFER_LAST) begin
            phase    <= PH_GAP_B;
            phaseCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        PH_GAP_B: phase <= PH_IDLE;
        default:  phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.sampleOn = enable && (phase == PH_SAMPLE);
    stb.xferOn   = enable && (phase == PH_XFER);
    stb.advance  = enable && (phase == PH_GAP_B);
  end

endmodule

// File: rtl/calseq_dpath.sv
module calseq_dpath
  import calseq_pkg::*;
#(
  parameter int CELLS = 32,
  localparam int IW   = $clog2(CELLS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  seqStrobes_t      stb,
  output logic [CELLS-1:0] cellSel,
  output logic             sampleStb,
  output logic             xferStb,
  output logic [IW-1:0]    activeIdx
);

  localparam logic [IW-1:0] LAST_IDX = IW'(CELLS - 1);

  logic [IW-1:0] idxQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ <= '0;
    end else if (stb.advance) begin
      idxQ <= (idxQ == LAST_IDX) ? '0 : idxQ + 1'b1;
    end
  end

  for (genvar g = 0; g < CELLS; g++) begin : g_sel
    assign cellSel[g] = enable && (idxQ == IW'(g));
  end

  assign sampleStb = stb.sampleOn;
  assign xferStb   = stb.xferOn;
  assign activeIdx = idxQ;

endmodule

// File: rtl/calib_sequencer.sv
module calib_sequencer
  import calseq_pkg::*;
#(
  parameter int CELLS      = 32,
  parameter int SAMPLE_LEN = 4,
  parameter int XFER_LEN   = 3,
  localparam int IW        = $clog2(CELLS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             trimTick,
  output logic [CELLS-1:0] cellSel,
  output logic             sampleStb,
  output logic             xferStb,
  output logic [IW-1:0]    activeIdx
);

  seqStrobes_t stb;

  calseq_ctrl #(
    .SAMPLE_LEN(SAMPLE_LEN),
    .XFER_LEN  (XFER_LEN)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .trimTick(trimTick),
    .stb     (stb)
  );

  calseq_dpath #(
    .CELLS(CELLS)
  ) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .stb      (stb),
    .cellSel  (cellSel),
    .sampleStb(sampleStb),
    .xferStb  (xferStb),
    .activeIdx(activeIdx)
  );

endmodule

// File: rtl/calib_sequencer_chk.sv
module calib_sequencer_chk #(
  parameter int CELLS = 32,
  localparam int IW   = $clog2(CELLS)
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic [CELLS-1:0] cellSel,
  input logic             sampleStb,
  input logic             xferStb,
  input logic [IW-1:0]    activeIdx
);

  localparam logic [IW-1:0] LAST_IDX = IW'(CELLS - 1);

  logic xferSeen;
  always_ff @(posedge clk) begin
    if (!rstN) xferSeen <= 1'b0;
    else if (xferStb) xferSeen <= 1'b1;
    else if (activeIdx != $past(activeIdx)) xferSeen <= 1'b0;
  end

  // R3
  p_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    enable |-> ($countones(cellSel) == 1 && cellSel[activeIdx]));

  // R9
  p_released_r9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (cellSel == '0 && !sampleStb && !xferStb));

  p_idx_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> $stable(activeIdx));

  // R6
  p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleStb && xferStb));

  p_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xferStb) |-> !$past(sampleStb));

  // R2
  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (activeIdx != $past(activeIdx)) |->
      (activeIdx == (($past(activeIdx) == LAST_IDX) ? '0 : $past(activeIdx) + 1'b1)));

  // R7
  p_xfer_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (activeIdx != $past(activeIdx)) |-> !$past(xferStb));

  p_xfer_first_r7: assert property (@(posedge clk) disable iff (!rstN)
    (activeIdx != $past(activeIdx)) |-> $past(xferSeen));

endmodule

bind calib_sequencer calib_sequencer_chk #(.CELLS(CELLS)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .enable   (enable),
  .cellSel  (cellSel),
  .sampleStb(sampleStb),
  .xferStb  (xferStb),
  .activeIdx(activeIdx)
);

// File: tb/test_calib_sequencer.sv
module test_calib_sequencer;

  localparam int CELLS = 32;
  localparam int S     = 4;
  localparam int X     = 3;
  localparam int SPAN  = S + X + 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        trimTick = 1'b0;
  logic [31:0] cellSel;
  logic        sampleStb;
  logic        xferStb;
  logic [4:0]  activeIdx;

  int errors = 0;
  int checks = 0;
  int expQ[$];
  int prevIdx = 0;
  bit monOn = 1'b0;

  always #4 clk = ~clk;

  calib_sequencer #(.CELLS(CELLS), .SAMPLE_LEN(S), .XFER_LEN(X)) i_calib_sequencer (
    .clk(clk), .rstN(rstN), .enable(enable), .trimTick(trimTick),
    .cellSel(cellSel), .sampleStb(sampleStb), .xferStb(xferStb), .activeIdx(activeIdx)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: pops the expected index on every observed change.
  always @(negedge clk) begin
    if (monOn) begin
      if (int'(activeIdx) != prevIdx) begin
        if (expQ.size() == 0) chk("R2 unexpected advance", activeIdx, prevIdx);
        else chk("R2 advance", activeIdx, expQ.pop_front());
        prevIdx = int'(activeIdx);
      end
      if (enable) chk("R3 one-hot select", cellSel, 32'h1 << activeIdx);
    end
  end

  // Driver: one handover, optional extra tick in the middle (R8).
  task automatic handover(input bit extraTick);
    int startIdx = int'(activeIdx);
    @(negedge clk);
    trimTick = 1'b1;
    expQ.push_back((startIdx + 1) % CELLS);
    for (int k = 1; k <= SPAN; k++) begin
      @(negedge clk);
      trimTick = (extraTick && k == 3);
      #1;
      chk("R4 sample window", sampleStb, k <= S);
      chk("R5 transfer window", xferStb, (k >= S + 2) && (k <= S + 1 + X));
      if (k < SPAN) chk("R7 index held before switch", activeIdx, startIdx);
    end
    @(negedge clk);
    #1;
    chk("R7 switch timing", activeIdx, (startIdx + 1) % CELLS);
    chk("R8 no restart", sampleStb, 0);
    repeat (3) @(negedge clk);
    chk("R8 no second advance", activeIdx, (startIdx + 1) % CELLS);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int hold;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 reset index", activeIdx, 0);
    chk("R1 reset sample", sampleStb, 0);
    chk("R1 reset xfer", xferStb, 0);
    chk("R9 select low while disabled", cellSel, 0);
    prevIdx = 0;
    monOn = 1'b1;
    @(negedge clk);
    enable = 1'b1;
    #1;
    chk("R3 cell 0 selected", cellSel, 32'h1);

    handover(1'b0);
    handover(1'b1);

    // R9: abandon a handover mid-sample
    hold = int'(activeIdx);
    @(negedge clk);
    trimTick = 1'b1;
    @(negedge clk);
    trimTick = 1'b0;
    @(negedge clk);
    enable = 1'b0;
    #1;
    chk("R9 select released", cellSel, 0);
    chk("R9 sample cut", sampleStb, 0);
    repeat (SPAN + 2) @(negedge clk);
    chk("R9 index held", activeIdx, hold);
    enable = 1'b1;
    for (int k = 0; k < SPAN + 3; k++) begin
      @(negedge clk);
      #1;
      chk("R9 no resume", sampleStb | xferStb, 0);
    end
    chk("R9 index kept after resume", activeIdx, hold);

    // R10: tick while disabled
    @(negedge clk);
    enable = 1'b0;
    trimTick = 1'b1;
    @(negedge clk);
    trimTick = 1'b0;
    enable = 1'b1;
    repeat (SPAN + 3) @(negedge clk);
    chk("R10 disabled tick ignored", activeIdx, hold);

    // R2: run around the ring through the wrap
    for (int n = 0; n < CELLS; n++) handover(1'b0);
    chk("R2 full ring returns", activeIdx, hold);
    while (activeIdx != 5'd31) handover(1'b0);
    handover(1'b0);
    chk("R2 wrap to zero", activeIdx, 0);

    chk("R2 scoreboard drained", expQ.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule